// File: doc/BRIEF.md
# Interleaved Four-Bank Cache Line Fill Controller

This block fetches 16-byte cache lines from four 32-bit memory banks that are interleaved by word. A miss request carries a line address. The controller sends the four word reads of that line to banks 0, 1, 2 and 3 on consecutive clocks. It does not wait for an earlier bank to answer before it asks the next one, so the access latencies of the banks overlap. After each request a bank must rest for a full cycle time before it can take another request. A small down-counter for each bank enforces that rest. The returned words are put together in order, and the finished 128-bit line is presented with a one-cycle done strobe.

When the last word of a fill is being requested, the controller also starts a look-ahead fill of the next sequential line. That fill is issued word by word as each bank becomes free again. If the next miss is for that line, the fill is promoted and finishes early, or at once if its data is already in. A miss to any other line drops the look-ahead. Its returned data is then thrown away, but the rest time of every bank it used is still honoured.

Miss requests use a valid/ready handshake. A miss is accepted in any cycle in which `miss_valid` and `miss_ready` are both high, and `miss_line` must stay stable while `miss_valid` is high. `miss_ready` is low from the cycle after an acceptance until the cycle in which that fill's `fill_done` is high. The requester may hold `miss_valid` high for as long as it likes while it waits. Each bank must return a word exactly once for each request, after a fixed latency that is no larger than the cycle time. The rest time is the parameter `CYC_T`.

Top module: `lfill_ctrl`

## Requirements
- R1: After a synchronous active-high reset, `miss_ready` is 1, `bank_req` is 0 and `fill_done` is 0. Any pending fill or look-ahead is forgotten, and every bank is free.
- R2: A miss is accepted when `miss_valid` and `miss_ready` are both high. `miss_ready` is low from the next cycle until the cycle in which that fill's `fill_done` is high; `miss_ready` is high in that cycle.
- R3: A demand fill requests word k of the line from bank k (`bank_req` bit k) in the order k = 0, 1, 2, 3, one request per cycle at most. `bank_line` carries the line address. Word 0 is requested in the cycle after acceptance if bank 0 is free, and otherwise in the first cycle in which it is free.
- R4: After a request in cycle c, a bank receives no further request before cycle c + `CYC_T`.
- R5: `bank_req` has at most one bit set in any cycle. A demand fill takes priority over a look-ahead fill.
- R6: `fill_data` holds the returned word k at bits [32k+31:32k], so byte 0 sits in the least significant bits. `fill_done` is high for exactly one cycle, the cycle after the last word of the fill is returned.
- R7: In the cycle in which a demand fill requests word 3, a look-ahead fill of line address + 1 begins. Its words are requested in order as each bank becomes free.
- R8: A miss whose address equals the look-ahead line promotes the look-ahead without new requests to banks. `fill_done` comes in the cycle after its last word returns, and no earlier than two cycles after acceptance. When a promoted look-ahead had already requested all four words, a new look-ahead of the next line begins in the accepting cycle.
- R9: A miss to any other address drops the look-ahead. Its outstanding data never appears in `fill_data`, and its bank rest times still apply to the new fill.
- R10: The look-ahead line address is the line address plus 1 modulo 2^`LINE_AW`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss request valid |
| miss_ready | output | 1 | Controller can accept a miss |
| miss_line | input | LINE_AW | Line address of the miss |
| bank_req | output | 4 | Read request, one bit per bank |
| bank_line | output | LINE_AW | Line address of the current bank request |
| bank_rvalid | input | 4 | Returned word valid, one bit per bank |
| bank_rdata | input | 128 | Returned words, bank k at bits [32k+31:32k] |
| fill_done | output | 1 | One-cycle strobe: line complete |
| fill_data | output | 128 | Assembled line, valid with `fill_done` |

## Verification
The controller is driven with several miss patterns, each of which shows a different behaviour.
- A cold first miss shows plain demand issue and how the line is put together.
- Back-to-back sequential misses, held valid under back-pressure, show whether the look-ahead is promoted while it is still being issued. They also show the steady rate of eight clocks per line.
- A sequential miss that arrives after a long idle gap separates a look-ahead whose data is complete from one still in flight.
- Misses that break the sequence show that dropped data is thrown away, including a drop just after the look-ahead has requested one word. In that case the new fill has to wait for that bank's rest time.
- A miss at the top line address checks that the look-ahead address wraps.

// File: rtl/lfill_pkg.sv
package lfill_pkg;
  localparam int NB     = 4;
  localparam int WW     = 32;
  localparam int LINE_W = NB * WW;
  localparam int IDX_W  = $clog2(NB);
  localparam int CNT_W  = IDX_W + 1;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_DMD   = 2'd1,
    SRC_AHEAD = 2'd2
  } src_e;
endpackage

// File: rtl/lfill_bank_timer.sv
module lfill_bank_timer #(
  parameter int CYC_T = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic free
);
  localparam int CW = (CYC_T > 2) ? $clog2(CYC_T) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(CYC_T - 1);

  logic [CW-1:0] rest_q;

  always_ff @(posedge clk) begin
    if (rst)                rest_q <= '0;
    else if (fire)          rest_q <= RELOAD;
    else if (rest_q != '0)  rest_q <= rest_q - 1'b1;
  end

  assign free = (rest_q == '0);
endmodule

// File: rtl/lfill_issue.sv
module lfill_issue
  import lfill_pkg::*;
(
  input  logic             dm_on,
  input  logic [CNT_W-1:0] dm_nxt,
  input  logic             la_on,
  input  logic [CNT_W-1:0] la_nxt,
  input  logic [NB-1:0]    bank_free,
  output logic [NB-1:0]    req,
  output src_e             src
);
  logic dm_ok, la_ok;

  always_comb begin
    dm_ok = dm_on && !dm_nxt[IDX_W] && bank_free[dm_nxt[IDX_W-1:0]];
    la_ok = la_on && !la_nxt[IDX_W] && bank_free[la_nxt[IDX_W-1:0]];
    req   = '0;
    src   = SRC_NONE;
    if (dm_ok) begin
      src = SRC_DMD;
      req[dm_nxt[IDX_W-1:0]] = 1'b1;
    end else if (la_ok) begin
      src = SRC_AHEAD;
      req[la_nxt[IDX_W-1:0]] = 1'b1;
    end
  end
endmodule

// File: rtl/lfill_ctrl.sv
module lfill_ctrl
  import lfill_pkg::*;
#(
  parameter int LINE_AW = 26,
  parameter int CYC_T   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               miss_valid,
  output logic               miss_ready,
  input  logic [LINE_AW-1:0] miss_line,
  output logic [NB-1:0]      bank_req,
  output logic [LINE_AW-1:0] bank_line,
  input  logic [NB-1:0]      bank_rvalid,
  input  logic [LINE_W-1:0]  bank_rdata,
  output logic               fill_done,
  output logic [LINE_W-1:0]  fill_data
);
  localparam logic [CNT_W-1:0] ALL_ISSUED = CNT_W'(NB);
  localparam logic [CNT_W-1:0] LAST_WORD  = CNT_W'(NB - 1);

  // demand context
  logic               dm_on;
  logic [LINE_AW-1:0] dm_line;
  logic [CNT_W-1:0]   dm_nxt, dm_nxt_n;
  logic [NB-1:0]      dm_got, dm_got_n, pend_dm, pend_dm_n;
  logic [LINE_W-1:0]  dm_data, dm_data_n;
  // look-ahead context
  logic               la_on;
  logic [LINE_AW-1:0] la_line;
  logic [CNT_W-1:0]   la_nxt, la_nxt_n;
  logic [NB-1:0]      la_got, la_got_n, pend_la, pend_la_n;
  logic [LINE_W-1:0]  la_data, la_data_n;

  logic [NB-1:0]      bank_free, to_dm, to_la;
  src_e               src;
  logic               accept, hit, complete, la_start;
  logic               done_q;
  logic [LINE_W-1:0]  line_q;

  for (genvar k = 0; k < NB; k++) begin : g_bank
    lfill_bank_timer #(.CYC_T(CYC_T)) u_timer (
      .clk  (clk),
      .rst  (rst),
      .fire (bank_req[k]),
      .free (bank_free[k])
    );
  end

  lfill_issue u_issue (
    .dm_on     (dm_on),
    .dm_nxt    (dm_nxt),
    .la_on     (la_on),
    .la_nxt    (la_nxt),
    .bank_free (bank_free),
    .req       (bank_req),
    .src       (src)
  );

  assign bank_line  = (src == SRC_AHEAD) ? la_line : dm_line;
  assign miss_ready = !dm_on;
  assign accept     = miss_valid && miss_ready;
  assign hit        = la_on && (la_line == miss_line);

  assign to_dm = bank_rvalid & pend_dm;
  assign to_la = bank_rvalid & pend_la;

  always_comb begin
    dm_data_n = dm_data;
    la_data_n = la_data;
    for (int k = 0; k < NB; k++) begin
      if (to_dm[k]) dm_data_n[k*WW +: WW] = bank_rdata[k*WW +: WW];
      if (to_la[k]) la_data_n[k*WW +: WW] = bank_rdata[k*WW +: WW];
    end
  end

  assign dm_got_n  = dm_got | to_dm;
  assign la_got_n  = la_got | to_la;
  assign dm_nxt_n  = dm_nxt + CNT_W'(src == SRC_DMD);
  assign la_nxt_n  = la_nxt + CNT_W'(src == SRC_AHEAD);
  assign pend_dm_n = (pend_dm & ~bank_rvalid) | ((src == SRC_DMD)   ? bank_req : '0);
  assign pend_la_n = (pend_la & ~bank_rvalid) | ((src == SRC_AHEAD) ? bank_req : '0);
  assign complete  = dm_on && (&dm_got_n);
  assign la_start  = ((src == SRC_DMD) && (dm_nxt == LAST_WORD))
                   || (accept && hit && (la_nxt_n == ALL_ISSUED));

  always_ff @(posedge clk) begin
    if (rst) begin
      dm_on   <= 1'b0;
      dm_line <= '0;
      dm_nxt  <= '0;
      dm_got  <= '0;
      pend_dm <= '0;
      la_on   <= 1'b0;
      la_line <= '0;
      la_nxt  <= '0;
      la_got  <= '0;
      pend_la <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q  <= complete;
      dm_on   <= dm_on && !complete;
      dm_nxt  <= dm_nxt_n;
      dm_got  <= dm_got_n;
      pend_dm <= pend_dm_n;
      la_nxt  <= la_nxt_n;
      la_got  <= la_got_n;
      pend_la <= pend_la_n;
      if (accept) begin
        dm_on   <= 1'b1;
        la_on   <= 1'b0;
        pend_la <= '0;
        if (hit) begin
          dm_line <= la_line;
          dm_nxt  <= la_nxt_n;
          dm_got  <= la_got_n;
          pend_dm <= pend_dm_n | pend_la_n;
        end else begin
          dm_line <= miss_line;
          dm_nxt  <= '0;
          dm_got  <= '0;
        end
      end
      if (la_start) begin
        la_on   <= 1'b1;
        la_line <= (accept ? la_line : dm_line) + 1'b1;
        la_nxt  <= '0;
        la_got  <= '0;
        pend_la <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    dm_data <= (accept && hit) ? la_data_n : dm_data_n;
    la_data <= la_data_n;
    if (complete) line_q <= dm_data_n;
  end

  assign fill_done = done_q;
  assign fill_data = line_q;
endmodule

// File: rtl/lfill_checks.sv
module lfill_checks
  import lfill_pkg::*;
#(
  parameter int LINE_AW = 26,
  parameter int CYC_T   = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               miss_valid,
  input logic               miss_ready,
  input logic [NB-1:0]      bank_req,
  input logic               fill_done
);
  localparam int GW = $clog2(CYC_T + 1);

  // R5: one bank request per cycle at most
  p_one_req_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_req));

  // R2: acceptance closes the handshake for the next cycle
  p_ready_drop_r2: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && miss_ready) |=> !miss_ready);

  // R2: the controller is ready again in the done cycle
  p_done_ready_r2: assert property (@(posedge clk) disable iff (rst)
    fill_done |-> miss_ready);

  // R6: done lasts a single cycle
  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    fill_done |=> !fill_done);

  for (genvar k = 0; k < NB; k++) begin : g_rest
    logic [GW-1:0] gap_q;
    always_ff @(posedge clk) begin
      if (rst)                          gap_q <= GW'(CYC_T);
      else if (bank_req[k])             gap_q <= GW'(1);
      else if (gap_q < GW'(CYC_T))      gap_q <= gap_q + 1'b1;
    end
    // R4: a bank rests a full cycle time between requests
    p_bank_rest_r4: assert property (@(posedge clk) disable iff (rst)
      bank_req[k] |-> (gap_q >= GW'(CYC_T)));
  end
endmodule

bind lfill_ctrl lfill_checks #(.LINE_AW(LINE_AW), .CYC_T(CYC_T)) u_lfill_checks (
  .clk        (clk),
  .rst        (rst),
  .miss_valid (miss_valid),
  .miss_ready (miss_ready),
  .bank_req   (bank_req),
  .fill_done  (fill_done)
);

// File: tb/tb_lfill_ctrl.sv
module tb_lfill_ctrl;
  localparam int LW   = 6;
  localparam int CYC  = 8;
  localparam int LAT  = 4;
  localparam int NS   = 12;
  localparam int WDOG = 5000;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           miss_valid = 1'b0;
  logic           miss_ready;
  logic [LW-1:0]  miss_line = '0;
  logic [3:0]     bank_req;
  logic [LW-1:0]  bank_line;
  logic [3:0]     bank_rvalid = '0;
  logic [127:0]   bank_rdata = '0;
  logic           fill_done;
  logic [127:0]   fill_data;

  always #2 clk = ~clk;

  lfill_ctrl #(.LINE_AW(LW), .CYC_T(CYC)) dut (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_line(miss_line), .bank_req(bank_req), .bank_line(bank_line),
    .bank_rvalid(bank_rvalid), .bank_rdata(bank_rdata),
    .fill_done(fill_done), .fill_data(fill_data)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(input logic [LW-1:0] ln, input int k);
    return (32'(ln) * 32'h9E37_79B1) ^ (32'(k) << 28) ^ 32'h005A_C300;
  endfunction

  function automatic logic [127:0] line_of(input logic [LW-1:0] ln);
    logic [127:0] v;
    for (int k = 0; k < 4; k++) v[k*32 +: 32] = word_of(ln, k);
    return v;
  endfunction

  // stimulus: line addresses and idle gaps before each
  int s_line [NS] = '{5, 6, 7, 20, 21, 40, 63, 0, 1, 0, 30, 9};
  int s_gap  [NS] = '{0, 0, 0, 0, 20, 3, 0, 0, 0, 0, 0, 0};

  // bank model
  int            ret_at   [4];
  logic [LW-1:0] ret_line [4];
  bit            ret_on   [4];
  int            last_req [4];

  // reference model
  int            cyc = 0;
  bit            m_dm_on, m_la_on, m_done, m_done_nx, m_from_la, m_dm_from_la;
  logic [LW-1:0] m_dm_line, m_la_line;
  int            m_dm_n, m_la_n;
  int            m_dm_arr [4];
  int            m_la_arr [4];
  int            free_at  [4];
  logic [127:0]  m_line, m_line_nx;
  int            head = 0, gap_until = 0;

  initial begin
    for (int k = 0; k < 4; k++) begin
      ret_on[k] = 0; ret_at[k] = 0; ret_line[k] = '0;
      last_req[k] = -1000; free_at[k] = -1000;
      m_dm_arr[k] = 0; m_la_arr[k] = 0;
    end
    m_dm_on = 0; m_la_on = 0; m_done = 0; m_done_nx = 0;
    m_from_la = 0; m_dm_from_la = 0;
    m_dm_line = '0; m_la_line = '0; m_dm_n = 0; m_la_n = 0;
    m_line = '0; m_line_nx = '0;

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: idle state right after reset
    chk(miss_ready == 1'b1, "R1", "ready after reset", 128'(miss_ready), 128'(1));
    chk(bank_req == 4'b0, "R1", "no request after reset", 128'(bank_req), 128'(0));
    chk(fill_done == 1'b0, "R1", "no done after reset", 128'(fill_done), 128'(0));

    while (cyc < WDOG) begin
      int  exp_b;
      bit  exp_la;
      logic [LW-1:0] exp_ln;
      logic [3:0] exp_req;
      bit  exp_rdy;

      @(posedge clk);
      #1;
      cyc++;
      for (int k = 0; k < 4; k++) begin
        bank_rvalid[k] = ret_on[k] && (ret_at[k] == cyc);
        bank_rdata[k*32 +: 32] = bank_rvalid[k] ? word_of(ret_line[k], k)
                                                : (32'hBAD0_0000 | 32'(cyc));
      end
      miss_valid = (head < NS) && (cyc >= gap_until);
      miss_line  = (head < NS) ? LW'(s_line[head]) : '0;

      @(negedge clk);

      // outputs of this cycle
      exp_rdy = !m_dm_on;
      chk(miss_ready == exp_rdy, "R2", "miss_ready", 128'(miss_ready), 128'(exp_rdy));
      chk(fill_done == m_done, "R6", "fill_done", 128'(fill_done), 128'(m_done));
      if (m_done && fill_done)
        chk(fill_data == m_line, m_from_la ? "R8" : "R6", "fill_data", fill_data, m_line);

      exp_b = -1; exp_la = 0; exp_ln = '0;
      if (m_dm_on && m_dm_n < 4 && free_at[m_dm_n] <= cyc) begin
        exp_b = m_dm_n; exp_ln = m_dm_line;
      end else if (m_la_on && m_la_n < 4 && free_at[m_la_n] <= cyc) begin
        exp_b = m_la_n; exp_ln = m_la_line; exp_la = 1;
      end
      exp_req = (exp_b >= 0) ? (4'b1 << exp_b) : 4'b0;
      chk(bank_req == exp_req, exp_la ? "R7" : "R3", "bank_req",
          128'(bank_req), 128'(exp_req));
      if (exp_b >= 0 && bank_req == exp_req)
        chk(bank_line == exp_ln, exp_la ? "R10" : "R3", "bank_line",
            128'(bank_line), 128'(exp_ln));

      // bank model and R4 rest check
      for (int k = 0; k < 4; k++) begin
        if (ret_on[k] && ret_at[k] == cyc) ret_on[k] = 0;
        if (bank_req[k]) begin
          chk(cyc - last_req[k] >= CYC, "R4", "bank reuse gap",
              128'(cyc - last_req[k]), 128'(CYC));
          last_req[k] = cyc;
          ret_on[k]   = 1;
          ret_at[k]   = cyc + LAT;
          ret_line[k] = bank_line;
        end
      end

      // model transitions at the end of this cycle
      m_done_nx = 0;
      if (exp_b >= 0) begin
        free_at[exp_b] = cyc + CYC;
        if (exp_la) begin m_la_arr[exp_b] = cyc + LAT; m_la_n++; end
        else        begin m_dm_arr[exp_b] = cyc + LAT; m_dm_n++; end
      end
      if (m_dm_on && m_dm_n == 4 && m_dm_arr[0] <= cyc && m_dm_arr[1] <= cyc
          && m_dm_arr[2] <= cyc && m_dm_arr[3] <= cyc) begin
        m_done_nx = 1;
        m_line_nx = line_of(m_dm_line);
        m_from_la = m_dm_from_la;
        m_dm_on   = 0;
      end
      if (miss_valid && exp_rdy) begin
        if (m_la_on && m_la_line == miss_line) begin
          // R8: promote the look-ahead
          m_dm_on = 1; m_dm_line = m_la_line; m_dm_n = m_la_n; m_dm_from_la = 1;
          for (int k = 0; k < 4; k++) m_dm_arr[k] = m_la_arr[k];
          m_la_on = 0;
          if (m_dm_n == 4) begin
            m_la_on = 1; m_la_line = m_dm_line + 1'b1; m_la_n = 0;
          end
        end else begin
          // R9: drop the look-ahead
          m_dm_on = 1; m_dm_line = miss_line; m_dm_n = 0; m_dm_from_la = 0;
          for (int k = 0; k < 4; k++) m_dm_arr[k] = 1 << 30;
          m_la_on = 0;
        end
        head++;
        gap_until = cyc + 1 + ((head < NS) ? s_gap[head] : 0);
      end
      if (exp_b == 3 && !exp_la) begin
        m_la_on = 1; m_la_line = m_dm_line + 1'b1; m_la_n = 0;
        for (int k = 0; k < 4; k++) m_la_arr[k] = 1 << 30;
      end
      m_done = m_done_nx;
      m_line = m_line_nx;

      if (head >= NS && !m_dm_on && !m_done && cyc > gap_until + 20) break;
    end

    if (cyc >= WDOG) chk(1'b0, "R2", "watchdog expired", 128'(cyc), 128'(WDOG));
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule